// File: doc/BRIEF.md
# Single-Cycle RISC Subset Core

A 32-bit processor core that retires one instruction on every rising clock edge. It fetches, decodes, executes, accesses data memory and writes back all within one cycle, using its own instruction memory and data memory. It understands nine instructions: word load and store, five register-to-register ALU operations (add, subtract, and, or, signed set-on-less-than), branch-if-equal and an absolute jump.

Decoding happens in two stages. A primary decoder looks only at the opcode field. It produces the single-bit datapath controls and a 2-bit class code, which is one of memory access, compare-for-branch or register operation. A secondary decoder turns that class code and the function field into a 3-bit ALU operation. The top bit of that operation tells the adder to invert its second operand and add one.

While reset is held, a debug port lets a host fill either memory and read words back. The same port can read any architectural register at any time. After reset is released, the core runs from address zero.

Top module: `rsc_core`

## Requirements
- R1: A synchronous active-high `rst` forces the program counter to 0 and all registers to 0. On the first edge after release, the core executes the word at byte address 0.
- R2: For opcode 000000, funct 100000 (add), 100010 (sub), 100100 (and) and 100101 (or) write rs op rt into rd. Fields are rs=[25:21], rt=[20:16], rd=[15:11] and funct=[5:0]. Add and subtract wrap modulo 2^32.
- R3: Opcode 000000 with funct 101010 writes 1 to rd when rs < rt as signed two's-complement values, and writes 0 otherwise.
- R4: Opcode 100011 (load) writes data memory word [(rs + sign-extended imm[15:0]) bits (AW+1):2] into rt, where AW = log2(MEM_WORDS).
- R5: Opcode 101011 (store) writes rt into the data memory word at the same address as R4 and changes no register.
- R6: Opcode 000100 sets the PC to PC+4 + (sign-extended imm << 2) when rs equals rt, and to PC+4 otherwise. Negative offsets branch backward.
- R7: Opcode 000010 sets the PC to {PC+4[31:28], instr[25:0], 2'b00}.
- R8: Register 0 always reads as zero, and writes addressed to it are discarded.
- R9: Any other opcode, and opcode 000000 with any other funct, changes no register or memory and advances the PC by 4.
- R10: While `rst` is high, `dbg_imem_we`/`dbg_dmem_we` write `dbg_wdata` to word `dbg_addr` on the clock edge. `dbg_rdata` shows instruction memory when `dbg_rd_imem`=1 and data memory otherwise. `dbg_reg_rdata` shows register `dbg_reg_sel`. All three reads are combinational.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| dbg_imem_we | input | 1 | Debug write strobe for instruction memory |
| dbg_dmem_we | input | 1 | Debug write strobe for data memory |
| dbg_addr | input | AW | Debug word index |
| dbg_wdata | input | 32 | Debug write data |
| dbg_rd_imem | input | 1 | Debug read selects instruction memory (1) or data memory (0) |
| dbg_rdata | output | 32 | Debug memory read data |
| dbg_reg_sel | input | 5 | Register index for debug read |
| dbg_reg_rdata | output | 32 | Debug register read data |
| pc | output | 32 | Current program counter |

## Verification
The assertions assume that memories are loaded only while `rst` is high. They also assume that the debug write strobes are low once the core runs, because a debug write would otherwise override a store. The bench follows both rules: it fills both memories before it releases reset, and after release it only reads. The assertions also assume that the program never jumps beyond the instruction memory in a way that matters. Because word indices wrap, the stimulus keeps every fetch and data access inside the first 64 words and ends in a jump-to-self loop.

// File: rtl/rsc_pkg.sv
package rsc_pkg;

   localparam logic [5:0] OPC_RTYPE = 6'b000000;
   localparam logic [5:0] OPC_LOAD  = 6'b100011;
   localparam logic [5:0] OPC_STORE = 6'b101011;
   localparam logic [5:0] OPC_BEQ   = 6'b000100;
   localparam logic [5:0] OPC_JUMP  = 6'b000010;

   localparam logic [5:0] FN_ADD = 6'b100000;
   localparam logic [5:0] FN_SUB = 6'b100010;
   localparam logic [5:0] FN_AND = 6'b100100;
   localparam logic [5:0] FN_OR  = 6'b100101;
   localparam logic [5:0] FN_SLT = 6'b101010;

   // top bit = invert operand B and carry in one
   typedef enum logic [2:0] {
      ALU_AND = 3'b000,
      ALU_OR  = 3'b001,
      ALU_ADD = 3'b010,
      ALU_SUB = 3'b110,
      ALU_SLT = 3'b111
   } alu_op_e;

   typedef enum logic [1:0] {
      CLS_MEM   = 2'b00,
      CLS_CMP   = 2'b01,
      CLS_REGOP = 2'b10,
      CLS_NONE  = 2'b11
   } op_class_e;

   typedef struct packed {
      logic      dst_rd;
      logic      b_imm;
      logic      load;
      logic      store;
      logic      branch;
      logic      jump;
      logic      reg_we;
      op_class_e cls;
   } ctrl_t;

endpackage

// File: rtl/rsc_main_dec.sv
module rsc_main_dec
   import rsc_pkg::*;
(
   input  logic [5:0] opcode,
   output ctrl_t      ctrl
);

   always_comb begin
      ctrl     = '0;
      ctrl.cls = CLS_NONE;
      unique case (opcode)
         OPC_RTYPE: begin
            ctrl.dst_rd = 1'b1;
            ctrl.reg_we = 1'b1;
            ctrl.cls    = CLS_REGOP;
         end
         OPC_LOAD: begin
            ctrl.b_imm  = 1'b1;
            ctrl.load   = 1'b1;
            ctrl.reg_we = 1'b1;
            ctrl.cls    = CLS_MEM;
         end
         OPC_STORE: begin
            ctrl.b_imm = 1'b1;
            ctrl.store = 1'b1;
            ctrl.cls   = CLS_MEM;
         end
         OPC_BEQ: begin
            ctrl.branch = 1'b1;
            ctrl.cls    = CLS_CMP;
         end
         OPC_JUMP: ctrl.jump = 1'b1;
         default: ;
      endcase
   end

endmodule

// File: rtl/rsc_alu_dec.sv
module rsc_alu_dec
   import rsc_pkg::*;
(
   input  op_class_e  cls,
   input  logic [5:0] funct,
   output alu_op_e    op,
   output logic       op_ok
);

   always_comb begin
      op    = ALU_ADD;
      op_ok = 1'b1;
      unique case (cls)
         CLS_MEM: op = ALU_ADD;
         CLS_CMP: op = ALU_SUB;
         CLS_REGOP: begin
            unique case (funct)
               FN_ADD:  op = ALU_ADD;
               FN_SUB:  op = ALU_SUB;
               FN_AND:  op = ALU_AND;
               FN_OR:   op = ALU_OR;
               FN_SLT:  op = ALU_SLT;
               default: op_ok = 1'b0;
            endcase
         end
         default: op_ok = 1'b0;
      endcase
   end

endmodule

// File: rtl/rsc_alu.sv
module rsc_alu
   import rsc_pkg::*;
#(
   parameter int W = 32
) (
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   input  alu_op_e      op,
   output logic [W-1:0] y,
   output logic         zero
);

   logic          inv_b;
   logic [W-1:0]  b_eff;
   logic [W-1:0]  sum;
   logic          lt_signed;

   assign inv_b = op[2];
   assign b_eff = inv_b ? ~b : b;
   assign sum   = a + b_eff + {{(W-1){1'b0}}, inv_b};
   // signed less-than from the difference and operand signs
   assign lt_signed = (a[W-1] != b[W-1]) ? a[W-1] : sum[W-1];

   always_comb begin
      unique case (op)
         ALU_AND: y = a & b;
         ALU_OR:  y = a | b;
         ALU_SLT: y = {{(W-1){1'b0}}, lt_signed};
         default: y = sum;
      endcase
   end

   assign zero = (sum == '0);

endmodule

// File: rtl/rsc_regfile.sv
module rsc_regfile #(
   parameter int W  = 32,
   parameter int N  = 32,
   localparam int RAW = $clog2(N)
) (
   input  logic           clk,
   input  logic           rst,
   input  logic           we,
   input  logic [RAW-1:0] wa,
   input  logic [W-1:0]   wd,
   input  logic [RAW-1:0] ra1,
   input  logic [RAW-1:0] ra2,
   input  logic [RAW-1:0] ra3,
   output logic [W-1:0]   rd1,
   output logic [W-1:0]   rd2,
   output logic [W-1:0]   rd3
);

   logic [W-1:0] regs [N];

   for (genvar i = 0; i < N; i++) begin : g_reg
      if (i == 0) begin : g_hard_zero
         assign regs[i] = '0;
      end else begin : g_store
         always_ff @(posedge clk) begin
            if (rst)
               regs[i] <= '0;
            else if (we && (wa == RAW'(i)))
               regs[i] <= wd;
         end
      end
   end

   assign rd1 = regs[ra1];
   assign rd2 = regs[ra2];
   assign rd3 = regs[ra3];

endmodule

// File: rtl/rsc_mem.sv
module rsc_mem #(
   parameter int W     = 32,
   parameter int DEPTH = 64,
   localparam int AW   = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          we,
   input  logic [AW-1:0] wa,
   input  logic [W-1:0]  wd,
   input  logic [AW-1:0] ra_a,
   output logic [W-1:0]  rd_a,
   input  logic [AW-1:0] ra_b,
   output logic [W-1:0]  rd_b
);

   logic [W-1:0] words [DEPTH];

   always_ff @(posedge clk) begin
      if (we) words[wa] <= wd;
   end

   assign rd_a = words[ra_a];
   assign rd_b = words[ra_b];

endmodule

// File: rtl/rsc_core.sv
module rsc_core
   import rsc_pkg::*;
#(
   parameter int XLEN      = 32,
   parameter int NREGS     = 32,
   parameter int MEM_WORDS = 64,
   localparam int AW  = $clog2(MEM_WORDS),
   localparam int RAW = $clog2(NREGS)
) (
   input  logic            clk,
   input  logic            rst,
   input  logic            dbg_imem_we,
   input  logic            dbg_dmem_we,
   input  logic [AW-1:0]   dbg_addr,
   input  logic [XLEN-1:0] dbg_wdata,
   input  logic            dbg_rd_imem,
   output logic [XLEN-1:0] dbg_rdata,
   input  logic [RAW-1:0]  dbg_reg_sel,
   output logic [XLEN-1:0] dbg_reg_rdata,
   output logic [XLEN-1:0] pc
);

   if (XLEN != 32) begin : g_bad_xlen
      $error("rsc_core: XLEN must be 32");
   end
   if (NREGS != 32) begin : g_bad_nregs
      $error("rsc_core: NREGS must be 32 (5-bit register fields)");
   end
   if ((MEM_WORDS < 2) || (MEM_WORDS != (1 << AW)) || (AW > XLEN - 2)) begin : g_bad_mem
      $error("rsc_core: MEM_WORDS must be a power of two that fits the address");
   end

   logic [XLEN-1:0] pc_q, pc_plus4, pc_next, br_target, jmp_target;
   logic [XLEN-1:0] instr, imm_ext, rs_val, rt_val, alu_b, alu_y;
   logic [XLEN-1:0] ld_data, wb_data, dm_wd, im_dbg, dm_dbg, unused_rd;
   logic [RAW-1:0]  wb_addr;
   logic [AW-1:0]   dm_wa;
   ctrl_t           ctrl;
   alu_op_e         alu_op;
   logic            alu_ok, alu_zero, rf_we, dm_we, br_taken, is_jump;

   // ---------------- fetch ----------------
   rsc_mem #(.W(XLEN), .DEPTH(MEM_WORDS)) u_imem (
      .clk  (clk),
      .we   (dbg_imem_we & rst),
      .wa   (dbg_addr),
      .wd   (dbg_wdata),
      .ra_a (pc_q[AW+1:2]),
      .rd_a (instr),
      .ra_b (dbg_addr),
      .rd_b (im_dbg)
   );

   // ---------------- decode ----------------
   rsc_main_dec u_main_dec (
      .opcode (instr[31:26]),
      .ctrl   (ctrl)
   );

   rsc_alu_dec u_alu_dec (
      .cls   (ctrl.cls),
      .funct (instr[5:0]),
      .op    (alu_op),
      .op_ok (alu_ok)
   );

   assign imm_ext = {{(XLEN-16){instr[15]}}, instr[15:0]};
   assign wb_addr = ctrl.dst_rd ? instr[15:11] : instr[20:16];
   assign rf_we   = ctrl.reg_we & alu_ok & ~rst;

   rsc_regfile #(.W(XLEN), .N(NREGS)) u_rf (
      .clk (clk),
      .rst (rst),
      .we  (rf_we),
      .wa  (wb_addr),
      .wd  (wb_data),
      .ra1 (instr[25:21]),
      .ra2 (instr[20:16]),
      .ra3 (dbg_reg_sel),
      .rd1 (rs_val),
      .rd2 (rt_val),
      .rd3 (dbg_reg_rdata)
   );

   // ---------------- execute ----------------
   assign alu_b = ctrl.b_imm ? imm_ext : rt_val;

   rsc_alu #(.W(XLEN)) u_alu (
      .a    (rs_val),
      .b    (alu_b),
      .op   (alu_op),
      .y    (alu_y),
      .zero (alu_zero)
   );

   // ---------------- memory ----------------
   assign dm_we = ctrl.store & ~rst;
   assign dm_wa = (dbg_dmem_we & rst) ? dbg_addr : alu_y[AW+1:2];
   assign dm_wd = (dbg_dmem_we & rst) ? dbg_wdata : rt_val;

   rsc_mem #(.W(XLEN), .DEPTH(MEM_WORDS)) u_dmem (
      .clk  (clk),
      .we   (dm_we | (dbg_dmem_we & rst)),
      .wa   (dm_wa),
      .wd   (dm_wd),
      .ra_a (alu_y[AW+1:2]),
      .rd_a (ld_data),
      .ra_b (dbg_addr),
      .rd_b (dm_dbg)
   );

   assign wb_data   = ctrl.load ? ld_data : alu_y;
   assign dbg_rdata = dbg_rd_imem ? im_dbg : dm_dbg;

   // ---------------- next PC ----------------
   assign pc_plus4   = pc_q + XLEN'(4);
   assign br_target  = pc_plus4 + {imm_ext[XLEN-3:0], 2'b00};
   assign jmp_target = {pc_plus4[XLEN-1:28], instr[25:0], 2'b00};
   assign br_taken   = ctrl.branch & alu_zero;
   assign is_jump    = ctrl.jump;

   always_comb begin
      if (is_jump)       pc_next = jmp_target;
      else if (br_taken) pc_next = br_target;
      else               pc_next = pc_plus4;
   end

   always_ff @(posedge clk) begin
      if (rst) pc_q <= '0;
      else     pc_q <= pc_next;
   end

   assign pc        = pc_q;
   assign unused_rd = {instr[10:6], pc_q[1:0], alu_y[XLEN-1:AW+2], {(XLEN-7-(XLEN-AW-2)){1'b0}}};

endmodule

// File: rtl/rsc_core_chk.sv
module rsc_core_chk #(
   parameter int XLEN = 32,
   parameter int RAW  = 5
) (
   input logic            clk,
   input logic            rst,
   input logic [XLEN-1:0] pc_q,
   input logic            is_jump,
   input logic            br_taken,
   input logic            dm_we,
   input logic            rf_we,
   input logic [RAW-1:0]  dbg_reg_sel,
   input logic [XLEN-1:0] dbg_reg_rdata
);

   // R1
   rst_pc_zero_chk: assert property (@(posedge clk) rst |=> (pc_q == '0));

   // R9
   seq_advance_chk: assert property (@(posedge clk) disable iff (rst)
      (!is_jump && !br_taken) |=> (pc_q == $past(pc_q) + XLEN'(4)));

   // R6
   pc_aligned_chk: assert property (@(posedge clk) disable iff (rst)
      pc_q[1:0] == 2'b00);

   // R5
   store_no_wb_chk: assert property (@(posedge clk) disable iff (rst)
      dm_we |-> !rf_we);

   // R8
   zero_reg_chk: assert property (@(posedge clk) disable iff (rst)
      (dbg_reg_sel == '0) |-> (dbg_reg_rdata == '0));

   // R1
   no_write_in_rst_chk: assert property (@(posedge clk)
      rst |-> (!dm_we && !rf_we));

endmodule

bind rsc_core rsc_core_chk #(.XLEN(XLEN), .RAW(RAW)) u_chk (
   .clk           (clk),
   .rst           (rst),
   .pc_q          (pc_q),
   .is_jump       (is_jump),
   .br_taken      (br_taken),
   .dm_we         (dm_we),
   .rf_we         (rf_we),
   .dbg_reg_sel   (dbg_reg_sel),
   .dbg_reg_rdata (dbg_reg_rdata)
);

// File: tb/rsc_core_tb.sv
`timescale 1ns/1ps
module rsc_core_tb;

   localparam int AW = 6;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          dbg_imem_we = 1'b0, dbg_dmem_we = 1'b0, dbg_rd_imem = 1'b0;
   logic [AW-1:0] dbg_addr = '0;
   logic [31:0]   dbg_wdata = '0;
   logic [31:0]   dbg_rdata, dbg_reg_rdata, pc;
   logic [4:0]    dbg_reg_sel = '0;

   int n_chk = 0, n_fail = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   rsc_core u_dut (
      .clk(clk), .rst(rst),
      .dbg_imem_we(dbg_imem_we), .dbg_dmem_we(dbg_dmem_we),
      .dbg_addr(dbg_addr), .dbg_wdata(dbg_wdata),
      .dbg_rd_imem(dbg_rd_imem), .dbg_rdata(dbg_rdata),
      .dbg_reg_sel(dbg_reg_sel), .dbg_reg_rdata(dbg_reg_rdata),
      .pc(pc)
   );

   // behavioural reference state
   logic [31:0] m_imem [64];
   logic [31:0] m_dmem [64];
   logic [31:0] m_reg  [32];
   logic [31:0] m_pc;

   task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
      end
   endtask

   function automatic logic [31:0] rtype(input int rs, input int rt, input int rd, input logic [5:0] fn);
      return {6'd0, 5'(rs), 5'(rt), 5'(rd), 5'd0, fn};
   endfunction
   function automatic logic [31:0] itype(input logic [5:0] op, input int rs, input int rt, input int imm);
      return {op, 5'(rs), 5'(rt), 16'(imm)};
   endfunction
   function automatic logic [31:0] jtype(input int idx);
      return {6'b000010, 26'(idx)};
   endfunction

   task automatic put_imem(input int a, input logic [31:0] w);
      @(negedge clk);
      dbg_imem_we = 1'b1; dbg_addr = AW'(a); dbg_wdata = w;
      m_imem[a] = w;
      @(negedge clk);
      dbg_imem_we = 1'b0;
   endtask
   task automatic put_dmem(input int a, input logic [31:0] w);
      @(negedge clk);
      dbg_dmem_we = 1'b1; dbg_addr = AW'(a); dbg_wdata = w;
      m_dmem[a] = w;
      @(negedge clk);
      dbg_dmem_we = 1'b0;
   endtask

   task automatic wr_reg(input logic [4:0] r, input logic [31:0] v);
      if (r != 0) m_reg[r] = v;
   endtask

   // advance the reference by one instruction; tag names the requirement
   task automatic model_step(output string tag);
      logic [31:0] ins, a, b, sx, pc4, nxt, ea;
      ins = m_imem[m_pc[7:2]];
      a   = m_reg[ins[25:21]];
      b   = m_reg[ins[20:16]];
      sx  = {{16{ins[15]}}, ins[15:0]};
      pc4 = m_pc + 32'd4;
      nxt = pc4;
      ea  = a + sx;
      tag = "R9";
      case (ins[31:26])
         6'b000000: begin
            case (ins[5:0])
               6'b100000: begin wr_reg(ins[15:11], a + b); tag = "R2"; end
               6'b100010: begin wr_reg(ins[15:11], a - b); tag = "R2"; end
               6'b100100: begin wr_reg(ins[15:11], a & b); tag = "R2"; end
               6'b100101: begin wr_reg(ins[15:11], a | b); tag = "R2"; end
               6'b101010: begin
                  wr_reg(ins[15:11], ($signed(a) < $signed(b)) ? 32'd1 : 32'd0);
                  tag = "R3";
               end
               default: tag = "R9";
            endcase
         end
         6'b100011: begin wr_reg(ins[20:16], m_dmem[ea[7:2]]); tag = "R4"; end
         6'b101011: begin m_dmem[ea[7:2]] = b; tag = "R5"; end
         6'b000100: begin
            if (a == b) nxt = pc4 + {sx[29:0], 2'b00};
            tag = "R6";
         end
         6'b000010: begin nxt = {pc4[31:28], ins[25:0], 2'b00}; tag = "R7"; end
         default: tag = "R9";
      endcase
      m_pc = nxt;
   endtask

   initial begin
      string tag;
      for (int i = 0; i < 32; i++) m_reg[i] = '0;
      m_pc = '0;
      for (int i = 0; i < 64; i++) begin
         put_imem(i, 32'd0);
         put_dmem(i, 32'd0);
      end
      // data
      put_dmem(0, 32'h8000_0005);
      put_dmem(1, 32'd7);
      put_dmem(2, 32'hFFFF_FFF0);
      put_dmem(5, 32'd1);
      // program
      put_imem(0,  itype(6'b100011, 0, 1, 0));
      put_imem(1,  itype(6'b100011, 0, 2, 4));
      put_imem(2,  itype(6'b100011, 0, 3, 8));
      put_imem(3,  rtype(1, 2, 4, 6'b100000));
      put_imem(4,  rtype(2, 1, 5, 6'b100010));
      put_imem(5,  rtype(1, 2, 6, 6'b100100));
      put_imem(6,  rtype(1, 3, 7, 6'b100101));
      put_imem(7,  rtype(1, 2, 8, 6'b101010));
      put_imem(8,  rtype(2, 1, 9, 6'b101010));
      put_imem(9,  rtype(3, 2, 10, 6'b101010));
      put_imem(10, rtype(1, 2, 0, 6'b100000));
      put_imem(11, itype(6'b101011, 0, 4, 12));
      put_imem(12, itype(6'b101011, 0, 5, 16));
      put_imem(13, 32'hFC00_0000);
      put_imem(14, rtype(1, 2, 11, 6'b000000));
      put_imem(15, rtype(0, 2, 11, 6'b100000));
      put_imem(16, itype(6'b100011, 0, 13, 20));
      put_imem(17, rtype(11, 13, 11, 6'b100010));
      put_imem(18, itype(6'b000100, 11, 0, 1));
      put_imem(19, itype(6'b000100, 0, 0, -3));
      put_imem(20, itype(6'b000100, 0, 0, 1));
      put_imem(21, rtype(1, 1, 14, 6'b100000));
      put_imem(22, itype(6'b000100, 1, 2, 5));
      put_imem(23, jtype(26));
      put_imem(24, rtype(1, 1, 15, 6'b100000));
      put_imem(25, rtype(1, 1, 15, 6'b100000));
      put_imem(26, itype(6'b101011, 0, 11, 24));
      put_imem(27, jtype(27));

      // reset state and debug read-back
      @(negedge clk);
      chk("R1", "pc in reset", pc, 32'd0);
      dbg_reg_sel = 5'd4; #1;
      chk("R1", "reg in reset", dbg_reg_rdata, 32'd0);
      dbg_rd_imem = 1'b1; dbg_addr = 6'd3; #1;
      chk("R10", "imem readback", dbg_rdata, rtype(1, 2, 4, 6'b100000));
      dbg_rd_imem = 1'b0; dbg_addr = 6'd2; #1;
      chk("R10", "dmem readback", dbg_rdata, 32'hFFFF_FFF0);

      rst = 1'b0;
      for (int cyc = 0; cyc < 90; cyc++) begin
         model_step(tag);
         @(negedge clk);
         chk(tag, "pc", pc, m_pc);
         dbg_reg_sel = 5'(cyc);
         #1;
         chk((cyc % 32 == 0) ? "R8" : tag, "register", dbg_reg_rdata, m_reg[cyc % 32]);
      end

      // directed end-state checks
      chk("R7", "final pc (jump-to-self)", pc, 32'd108);
      dbg_reg_sel = 5'd1;  #1; chk("R4", "r1 loaded", dbg_reg_rdata, 32'h8000_0005);
      dbg_reg_sel = 5'd8;  #1; chk("R3", "slt neg<pos", dbg_reg_rdata, 32'd1);
      dbg_reg_sel = 5'd9;  #1; chk("R3", "slt pos<neg", dbg_reg_rdata, 32'd0);
      dbg_reg_sel = 5'd10; #1; chk("R3", "slt -16<7", dbg_reg_rdata, 32'd1);
      dbg_reg_sel = 5'd0;  #1; chk("R8", "r0 after write", dbg_reg_rdata, 32'd0);
      dbg_reg_sel = 5'd14; #1; chk("R6", "skipped by taken beq", dbg_reg_rdata, 32'd0);
      dbg_reg_sel = 5'd15; #1; chk("R7", "skipped by jump", dbg_reg_rdata, 32'd0);
      dbg_reg_sel = 5'd6;  #1; chk("R2", "and result", dbg_reg_rdata, 32'd5);
      dbg_addr = 6'd3; #1; chk("R5", "stored sum", dbg_rdata, 32'h8000_000C);
      dbg_addr = 6'd4; #1; chk("R2", "stored wrapped difference", dbg_rdata, 32'h8000_0002);
      dbg_addr = 6'd6; #1; chk("R6", "loop counter after backward branches", dbg_rdata, 32'd0);
      for (int i = 0; i < 64; i++) begin
         dbg_addr = AW'(i); #1;
         if (dbg_rdata !== m_dmem[i]) chk("R5", "data memory image", dbg_rdata, m_dmem[i]);
      end

      // reset again mid-run
      rst = 1'b1;
      @(negedge clk);
      chk("R1", "pc after re-reset", pc, 32'd0);
      dbg_reg_sel = 5'd4; #1;
      chk("R1", "reg after re-reset", dbg_reg_rdata, 32'd0);

      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual running expected finished");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

endmodule